// File: doc/BRIEF.md
# Condition Field Predicate Evaluator

This block tests a 4-bit condition field against a 4-bit pattern, one bit position at a time, with a 4-bit mask choosing which positions take part. For each position the block forms a term that is 1 only when that position is enabled and the condition bit equals the pattern bit. A two-bit form select then decides what is written to a 64-bit destination word. Reduce forms combine the four terms into one bit with OR or AND. The concatenate form places all four terms side by side in the low nibble.

When a record flag is set, the block also produces a 4-bit summary of the destination word. The summary reports the sign of the word against zero and carries an incoming sticky-overflow bit. The result, the summary and a valid flag are held in an output register that loads only on a valid strobe. A two-state machine tracks whether the register holds a result from the previous cycle:
- `ST_IDLE`: no result loaded last cycle. The transition `strobe` goes to `ST_LOADED`, and `no_strobe` stays in `ST_IDLE`.
- `ST_LOADED`: a result loaded last cycle. The transition `strobe` stays in `ST_LOADED`, and `no_strobe` returns to `ST_IDLE`.

The output valid flag is high exactly in `ST_LOADED`. Reset enters `ST_IDLE`.

Top module: `cfp_eval`

## Requirements
- R1: For each position i (0..3), term t[i] = mask[i] AND (mode_pat[i] == cond_field[i]). Vector bit i of each input port is position i.
- R2: With form_sel = 2'b00 (AND reduce), destination bit 0 = t[0]&t[1]&t[2]&t[3].
- R3: With form_sel = 2'b01 (OR reduce), destination bit 0 = t[0]|t[1]|t[2]|t[3].
- R4: In both reduce forms, destination bits 63:1 are zero.
- R5: With form_sel[1] = 1 (concatenate), result bit 3 = t[0], bit 2 = t[1], bit 1 = t[2], bit 0 = t[3], and bits 63:4 are zero.
- R6: A mask of 4'b0000 gives a destination of zero in both reduce forms, whatever the field and the pattern.
- R7: With record_en = 1, summary bit 0 = (result < 0, signed), bit 1 = (result > 0), bit 2 = (result == 0), and bit 3 = so_in. Exactly one of bits 2:0 is set.
- R8: With record_en = 0, the summary is 4'b0000. so_in then has no effect.
- R9: result_q and summary_q load on the clock edge where valid_in is 1. They keep their value on every edge where valid_in is 0.
- R10: valid_q is 1 in the cycle after each edge where valid_in is 1, and 0 otherwise. Reset clears result_q, summary_q and valid_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Strobe that loads the output register |
| cond_field | input | 4 | Condition field under test |
| mask | input | 4 | Per-position enable |
| mode_pat | input | 4 | Per-position expected value |
| form_sel | input | 2 | 00 AND reduce, 01 OR reduce, 1x concatenate |
| record_en | input | 1 | Produce the summary |
| so_in | input | 1 | Sticky-overflow bit copied into summary bit 3 |
| result_q | output | 64 | Registered destination word |
| summary_q | output | 4 | Registered summary |
| valid_q | output | 1 | Output register holds a fresh result |

## Verification
The hardest case to reach is a register that must hold while its inputs change. A hold only shows at the ports if the inputs move to values that would give a different result. The bench therefore loads one result, drives a contrasting pattern with the strobe low for several cycles, and checks that the old word and summary remain. Every combination of field, mask and pattern is swept under each form, so each reduction's single matching and single failing position is covered. The all-zero mask, and the summary bit 3 with the record flag cleared, are driven on purpose.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
    localparam int FIELD_W = 4;
    localparam int SUMM_W  = 4;

    typedef enum logic [1:0] {
        FORM_AND = 2'b00,
        FORM_OR  = 2'b01,
        FORM_CAT = 2'b10,
        FORM_CAX = 2'b11
    } form_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } state_t;

    localparam int SUM_LT = 0;
    localparam int SUM_GT = 1;
    localparam int SUM_EQ = 2;
    localparam int SUM_SO = 3;
endpackage

// File: rtl/cfp_terms.sv
module cfp_terms #(
    parameter int FW = 4
) (
    input  logic [FW-1:0] cond_field,
    input  logic [FW-1:0] mask,
    input  logic [FW-1:0] mode_pat,
    output logic [FW-1:0] terms
);
    for (genvar i = 0; i < FW; i++) begin : g_bit
        assign terms[i] = mask[i] & ~(mode_pat[i] ^ cond_field[i]);
    end
endmodule

// File: rtl/cfp_combine.sv
module cfp_combine #(
    parameter int FW     = 4,
    parameter int DATA_W = 64
) (
    input  logic [FW-1:0]     terms,
    input  logic [1:0]        form_sel,
    output logic [DATA_W-1:0] word
);
    localparam int PAD_R = DATA_W - 1;
    localparam int PAD_C = DATA_W - FW;

    logic              red_bit;
    logic [FW-1:0]     cat_bits;

    for (genvar i = 0; i < FW; i++) begin : g_rev
        assign cat_bits[FW-1-i] = terms[i];
    end

    always_comb begin
        red_bit = form_sel[0] ? (|terms) : (&terms);
        if (form_sel[1]) begin
            word = {{PAD_C{1'b0}}, cat_bits};
        end else begin
            word = {{PAD_R{1'b0}}, red_bit};
        end
    end
endmodule

// File: rtl/cfp_summary.sv
module cfp_summary #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] word,
    input  logic              record_en,
    input  logic              so_in,
    output logic [3:0]        summ
);
    import cfp_pkg::*;

    logic neg, zero;

    always_comb begin
        neg  = word[DATA_W-1];
        zero = (word == '0);
        summ = '0;
        if (record_en) begin
            summ[SUM_LT] = neg;
            summ[SUM_EQ] = zero;
            summ[SUM_GT] = ~neg & ~zero;
            summ[SUM_SO] = so_in;
        end
    end
endmodule

// File: rtl/cfp_eval.sv
module cfp_eval #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [3:0]        cond_field,
    input  logic [3:0]        mask,
    input  logic [3:0]        mode_pat,
    input  logic [1:0]        form_sel,
    input  logic              record_en,
    input  logic              so_in,
    output logic [DATA_W-1:0] result_q,
    output logic [3:0]        summary_q,
    output logic              valid_q
);
    import cfp_pkg::*;

    logic [FIELD_W-1:0] terms;
    logic [DATA_W-1:0]  word_d;
    logic [SUMM_W-1:0]  summ_d;
    state_t             state, state_nx;

    cfp_terms #(.FW(FIELD_W)) u_terms (
        .cond_field (cond_field),
        .mask       (mask),
        .mode_pat   (mode_pat),
        .terms      (terms)
    );

    cfp_combine #(.FW(FIELD_W), .DATA_W(DATA_W)) u_comb (
        .terms    (terms),
        .form_sel (form_sel),
        .word     (word_d)
    );

    cfp_summary #(.DATA_W(DATA_W)) u_summ (
        .word      (word_d),
        .record_en (record_en),
        .so_in     (so_in),
        .summ      (summ_d)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = valid_in ? ST_LOADED : ST_IDLE;
            ST_LOADED: state_nx = valid_in ? ST_LOADED : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q  <= '0;
            summary_q <= '0;
        end else if (valid_in) begin
            result_q  <= word_d;
            summary_q <= summ_d;
        end
    end

    assign valid_q = (state == ST_LOADED);
endmodule

// File: rtl/cfp_eval_chk.sv
module cfp_eval_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_in,
    input logic [1:0]        form_sel,
    input logic              record_en,
    input logic              so_in,
    input logic [DATA_W-1:0] result_q,
    input logic [3:0]        summary_q,
    input logic              valid_q
);
    p_reduce_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !form_sel[1]) |=> (result_q[DATA_W-1:1] == '0));

    p_cat_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && form_sel[1]) |=> (result_q[DATA_W-1:4] == '0));

    p_summary_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && record_en) |=> ($onehot(summary_q[2:0])
            && (summary_q[2] == (result_q == '0)) && (summary_q[3] == $past(so_in))));

    p_summary_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !record_en) |=> (summary_q == 4'b0000));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(result_q) && $stable(summary_q)));

    p_valid_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_q);

    p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_q);
endmodule

bind cfp_eval cfp_eval_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .form_sel  (form_sel),
    .record_en (record_en),
    .so_in     (so_in),
    .result_q  (result_q),
    .summary_q (summary_q),
    .valid_q   (valid_q)
);

// File: tb/cfp_eval_tb.sv
module cfp_eval_tb;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_in = 1'b0;
    logic [3:0]    cond_field = '0, mask = '0, mode_pat = '0;
    logic [1:0]    form_sel = '0;
    logic          record_en = 1'b0, so_in = 1'b0;
    logic [DW-1:0] result_q;
    logic [3:0]    summary_q;
    logic          valid_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    cfp_eval #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .cond_field(cond_field), .mask(mask), .mode_pat(mode_pat),
        .form_sel(form_sel), .record_en(record_en), .so_in(so_in),
        .result_q(result_q), .summary_q(summary_q), .valid_q(valid_q)
    );

    function automatic logic [DW-1:0] ref_word(input logic [3:0] c, m, p, input logic [1:0] f);
        logic [3:0] t;
        logic [DW-1:0] w = '0;
        for (int i = 0; i < 4; i++) t[i] = m[i] && (p[i] == c[i]);
        if (f[1]) begin
            for (int i = 0; i < 4; i++) w[3-i] = t[i];
        end else if (f[0]) begin
            w[0] = (t != 4'b0000);
        end else begin
            w[0] = (t == 4'b1111);
        end
        return w;
    endfunction

    function automatic logic [3:0] ref_summ(input logic [DW-1:0] w, input logic rec, so);
        logic [3:0] s = '0;
        if (rec) begin
            s[0] = ($signed(w) < 0);
            s[1] = ($signed(w) > 0);
            s[2] = (w == '0);
            s[3] = so;
        end
        return s;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] c, m, p, input logic [1:0] f, input logic rec, so);
        @(negedge clk);
        cond_field = c; mask = m; mode_pat = p; form_sel = f;
        record_en = rec; so_in = so; valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 reset result", result_q, '0);
        check("R10 reset summary", {60'd0, summary_q}, '0);
        check("R10 reset valid", {63'd0, valid_q}, '0);
    endtask

    task automatic t_sweep(input logic [1:0] f, input string tag);
        int bad = 0;
        for (int k = 0; k < 4096; k++) begin
            logic [3:0] c = k[3:0], m = k[7:4], p = k[11:8];
            load(c, m, p, f, 1'b0, 1'b0);
            if (result_q !== ref_word(c, m, p, f)) begin
                bad++;
                if (bad < 4) check(tag, result_q, ref_word(c, m, p, f));
            end
        end
        check({tag, " sweep mismatches"}, bad, 0);
    endtask

    task automatic t_directed();
        load(4'b1010, 4'b1111, 4'b1010, 2'b00, 1'b0, 1'b0);
        check("R2 all match AND", result_q, 64'd1);
        load(4'b1010, 4'b1111, 4'b1011, 2'b00, 1'b0, 1'b0);
        check("R2 one miss AND", result_q, 64'd0);
        load(4'b0000, 4'b0100, 4'b0000, 2'b01, 1'b0, 1'b0);
        check("R3 single hit OR", result_q, 64'd1);
        load(4'b0001, 4'b0001, 4'b0000, 2'b11, 1'b0, 1'b0);
        check("R5 R1 position0 miss", result_q, 64'd0);
        load(4'b0001, 4'b0001, 4'b0001, 2'b10, 1'b0, 1'b0);
        check("R5 position0 to bit3", result_q, 64'd8);
        load(4'b1000, 4'b1000, 4'b1000, 2'b10, 1'b0, 1'b0);
        check("R5 position3 to bit0", result_q, 64'd1);
    endtask

    task automatic t_zero_mask();
        load(4'b0110, 4'b0000, 4'b0110, 2'b00, 1'b0, 1'b0);
        check("R6 zero mask AND", result_q, 64'd0);
        load(4'b0110, 4'b0000, 4'b0110, 2'b01, 1'b0, 1'b0);
        check("R6 zero mask OR", result_q, 64'd0);
        check("R4 upper bits zero", result_q >> 1, 64'd0);
    endtask

    task automatic t_record();
        load(4'b1111, 4'b1111, 4'b1111, 2'b10, 1'b1, 1'b1);
        check("R7 positive with so", {60'd0, summary_q}, {60'd0, ref_summ(64'd15, 1'b1, 1'b1)});
        load(4'b1111, 4'b1111, 4'b0000, 2'b01, 1'b1, 1'b0);
        check("R7 zero result", {60'd0, summary_q}, {60'd0, 4'b0100});
        load(4'b1111, 4'b1111, 4'b1111, 2'b10, 1'b0, 1'b1);
        check("R8 record off", {60'd0, summary_q}, '0);
    endtask

    task automatic t_hold();
        load(4'b1111, 4'b1111, 4'b1111, 2'b10, 1'b1, 1'b1);
        check("R10 valid after strobe", {63'd0, valid_q}, 64'd1);
        @(negedge clk);
        cond_field = 4'b0000; mask = 4'b1111; mode_pat = 4'b1111;
        form_sel = 2'b00; record_en = 1'b1; so_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 result held", result_q, 64'd15);
        check("R9 summary held", {60'd0, summary_q}, {60'd0, 4'b1010});
        check("R10 valid drops", {63'd0, valid_q}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_directed();
        t_zero_mask();
        t_record();
        t_hold();
        t_sweep(2'b00, "R2 R1");
        t_sweep(2'b01, "R3");
        t_sweep(2'b10, "R5");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule